// File: doc/BRIEF.md
# Configurable DRAM Address Mapper

This block turns a flat byte address into the chip-select, row, bank and column fields of a DRAM device. The row, bank and column widths, the number of chip selects (one or two) and the data interface width can all be set. The block also reports the total number of addressable bytes that the settings imply, and flags any address that falls at or beyond that size.

The settings are held in shadow registers. They load only on a one-cycle apply strobe, so the mapping cannot shift under a transaction in flight. The field order follows the chip-select count. With a single chip select the address splits, from the top, into chip, row, bank and column. With two chip selects the chip bit moves down to sit between the row and the bank, so both devices share every row. The decode from address to fields is combinational from the shadow state.

Top module: `dram_addr_map`

## Requirements
- R1: After reset the active settings are 14 row bits, 3 bank bits, 10 column bits, one chip select and a 32-bit interface, so `map_size` reads 0x2000_0000.
- R2: Settings are captured at a rising clock edge where `cfg_apply` is 1 and take effect from the next cycle. Changes on the `cfg_*` inputs while `cfg_apply` is 0 leave `map_size` and the decoded fields unchanged.
- R3: `cfg_if_width` encodes the interface width as follows. Code 0 is 8 bits, code 1 is 16 bits, code 2 is 32 bits, code 3 is 16 bits plus ECC, code 4 is 32 bits plus ECC, and codes 5 to 7 are treated as 8 bits. The lowest log2(data bytes) address bits are a byte-lane offset that no field uses: 0 bits for 8, 1 for 16, 2 for 32.
- R4: With `cfg_two_cs` = 0 (one chip select) the chip field is 0 bits wide and `map_cs` is 0. The order from the most significant end is chip, row, bank, column.
- R5: With `cfg_two_cs` = 1 (two chip selects) the chip field is 1 bit wide. The order from the most significant end is row, chip, bank, column.
- R6: The column field starts just above the byte-lane offset. Each field takes exactly its configured number of bits, and output bits above that width are 0.
- R7: `map_size` equals 2^(row+bank+col) × chip selects × (data width / 8) bytes.
- R8: An interface with ECC lanes counts only its 16-bit or 32-bit data width in the size and in the byte-lane offset.
- R9: A row-bit setting above 31 is replaced by the default of 14 row bits when it is captured. A setting of exactly 31 is accepted.
- R10: `map_oor` is 1 exactly when `addr` ≥ `map_size`. When `map_oor` is 1 the field outputs carry no meaning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_apply | input | 1 | One-cycle strobe that loads the settings below |
| cfg_row_bits | input | 6 | Row address bits requested (0..31 valid) |
| cfg_bank_bits | input | 3 | Bank address bits |
| cfg_col_bits | input | 4 | Column address bits |
| cfg_two_cs | input | 1 | 0: one chip select, 1: two chip selects |
| cfg_if_width | input | 3 | Interface width code (see R3) |
| addr | input | 32 | Flat byte address |
| map_cs | output | 1 | Chip-select field |
| map_row | output | 31 | Row field |
| map_bank | output | 7 | Bank field |
| map_col | output | 15 | Column field |
| map_oor | output | 1 | Address at or beyond the addressable size |
| map_size | output | 64 | Addressable size in bytes |

## Verification
The bench builds each address by packing chosen field values in the order it expects, then checks that the decode gives those values back. A one-chip-select layout and a two-chip-select layout are both used, and the row's top bit is set in each case. A chip bit placed at the wrong level therefore shows up as a wrong row or a wrong chip value. A sweep over all eight width codes with a fixed field pattern separates the byte-lane offsets and confirms that the ECC codes give the same size as their plain data widths. Addresses at size−1 and at size, the 31-row extreme, invalid row settings, and setting changes without the strobe cover the range flag, the row fallback and the shadow hold.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;

  typedef enum logic [1:0] {
    ORD_CS_ROW_BANK_COL = 2'd0,
    ORD_ROW_CS_BANK_COL = 2'd2
  } map_order_e;

  // Byte-lane offset bits for an interface width code; ECC codes count data lanes only.
  function automatic logic [1:0] lane_bits(input logic [2:0] code);
    case (code)
      3'd1, 3'd3: return 2'd1;
      3'd2, 3'd4: return 2'd2;
      default:    return 2'd0;
    endcase
  endfunction

  // Keep the lowest w bits of v.
  function automatic logic [63:0] take_field(input logic [63:0] v, input logic [7:0] w);
    return v & ((64'd1 << w) - 64'd1);
  endfunction

  // log2 of the addressable size in bytes.
  function automatic logic [7:0] size_log2(input logic [7:0] r, input logic [7:0] b,
                                           input logic [7:0] c, input logic [7:0] cs,
                                           input logic [7:0] lane);
    return r + b + c + cs + lane;
  endfunction

endpackage

// File: rtl/dram_cfg_shadow.sv
module dram_cfg_shadow
  import dram_map_pkg::*;
#(
  parameter int ROW_CFG_W   = 6,
  parameter int BANK_CFG_W  = 3,
  parameter int COL_CFG_W   = 4,
  parameter int ROW_LIMIT   = 31,
  parameter int DEFAULT_ROW = 14,
  parameter int RESET_BANK  = 3,
  parameter int RESET_COL   = 10,
  parameter int RESET_WCODE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  apply,
  input  logic [ROW_CFG_W-1:0]  row_in,
  input  logic [BANK_CFG_W-1:0] bank_in,
  input  logic [COL_CFG_W-1:0]  col_in,
  input  logic                  two_cs_in,
  input  logic [2:0]            wcode_in,
  output logic [ROW_CFG_W-1:0]  row_q,
  output logic [BANK_CFG_W-1:0] bank_q,
  output logic [COL_CFG_W-1:0]  col_q,
  output logic                  two_cs_q,
  output logic [1:0]            lane_q,
  output map_order_e            order_q
);

  localparam logic [ROW_CFG_W-1:0]  ROW_RST  = ROW_CFG_W'(DEFAULT_ROW);
  localparam logic [BANK_CFG_W-1:0] BANK_RST = BANK_CFG_W'(RESET_BANK);
  localparam logic [COL_CFG_W-1:0]  COL_RST  = COL_CFG_W'(RESET_COL);
  localparam logic [2:0]            WC_RST   = 3'(RESET_WCODE);

  logic                 row_ok;
  logic [ROW_CFG_W-1:0] row_next;

  assign row_ok   = (int'(row_in) <= ROW_LIMIT);
  assign row_next = row_ok ? row_in : ROW_RST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q    <= ROW_RST;
      bank_q   <= BANK_RST;
      col_q    <= COL_RST;
      two_cs_q <= 1'b0;
      lane_q   <= lane_bits(WC_RST);
      order_q  <= ORD_CS_ROW_BANK_COL;
    end else if (apply) begin
      row_q    <= row_next;
      bank_q   <= bank_in;
      col_q    <= col_in;
      two_cs_q <= two_cs_in;
      lane_q   <= lane_bits(wcode_in);
      order_q  <= two_cs_in ? ORD_ROW_CS_BANK_COL : ORD_CS_ROW_BANK_COL;
    end
  end

endmodule

// File: rtl/dram_size_calc.sv
module dram_size_calc
  import dram_map_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 64,
  parameter int ROW_CFG_W  = 6,
  parameter int BANK_CFG_W = 3,
  parameter int COL_CFG_W  = 4
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [ROW_CFG_W-1:0]  row,
  input  logic [BANK_CFG_W-1:0] bank,
  input  logic [COL_CFG_W-1:0]  col,
  input  logic                  two_cs,
  input  logic [1:0]            lane,
  output logic [SIZE_W-1:0]     size,
  output logic                  oor
);

  logic [7:0] log2_size;

  assign log2_size = size_log2(8'(row), 8'(bank), 8'(col), 8'(two_cs), 8'(lane));
  assign size      = SIZE_W'(1) << log2_size;
  assign oor       = (SIZE_W'(addr) >= size);

endmodule

// File: rtl/dram_field_slicer.sv
module dram_field_slicer
  import dram_map_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ROW_CFG_W  = 6,
  parameter int BANK_CFG_W = 3,
  parameter int COL_CFG_W  = 4,
  parameter int ROW_OUT_W  = 31,
  parameter int BANK_OUT_W = 7,
  parameter int COL_OUT_W  = 15
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [ROW_CFG_W-1:0]  row,
  input  logic [BANK_CFG_W-1:0] bank,
  input  logic [COL_CFG_W-1:0]  col,
  input  logic                  two_cs,
  input  logic [1:0]            lane,
  input  map_order_e            order,
  output logic                  cs_f,
  output logic [ROW_OUT_W-1:0]  row_f,
  output logic [BANK_OUT_W-1:0] bank_f,
  output logic [COL_OUT_W-1:0]  col_f
);

  logic [63:0] a_lane, a_bank, a_top;
  logic [63:0] col_full, bank_full, row_full, cs_full;

  always_comb begin
    a_lane    = 64'(addr) >> lane;
    col_full  = take_field(a_lane, 8'(col));
    a_bank    = a_lane >> col;
    bank_full = take_field(a_bank, 8'(bank));
    a_top     = a_bank >> bank;
    if (order == ORD_CS_ROW_BANK_COL) begin
      row_full = take_field(a_top, 8'(row));
      cs_full  = take_field(a_top >> row, 8'(two_cs));
    end else begin
      cs_full  = take_field(a_top, 8'(two_cs));
      row_full = take_field(a_top >> two_cs, 8'(row));
    end
  end

  assign col_f  = COL_OUT_W'(col_full);
  assign bank_f = BANK_OUT_W'(bank_full);
  assign row_f  = ROW_OUT_W'(row_full);
  assign cs_f   = 1'(cs_full);

endmodule

// File: rtl/dram_addr_map.sv
module dram_addr_map
  import dram_map_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int ROW_FIELD_MAX  = 31,
  parameter int BANK_FIELD_MAX = 7,
  parameter int COL_FIELD_MAX  = 15,
  parameter int DEFAULT_ROW    = 14,
  parameter int SIZE_W         = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_apply,
  input  logic [5:0]                cfg_row_bits,
  input  logic [2:0]                cfg_bank_bits,
  input  logic [3:0]                cfg_col_bits,
  input  logic                      cfg_two_cs,
  input  logic [2:0]                cfg_if_width,
  input  logic [ADDR_W-1:0]         addr,
  output logic                      map_cs,
  output logic [ROW_FIELD_MAX-1:0]  map_row,
  output logic [BANK_FIELD_MAX-1:0] map_bank,
  output logic [COL_FIELD_MAX-1:0]  map_col,
  output logic                      map_oor,
  output logic [SIZE_W-1:0]         map_size
);

  localparam int ROW_CFG_W  = 6;
  localparam int BANK_CFG_W = $clog2(BANK_FIELD_MAX + 1);
  localparam int COL_CFG_W  = $clog2(COL_FIELD_MAX + 1);

  // Active settings, brought out by name for the checker.
  logic [ROW_CFG_W-1:0]  eff_row;
  logic [BANK_CFG_W-1:0] eff_bank;
  logic [COL_CFG_W-1:0]  eff_col;
  logic                  eff_two_cs;
  logic [1:0]            eff_lane;
  map_order_e            eff_order;

  dram_cfg_shadow #(
    .ROW_CFG_W  (ROW_CFG_W),
    .BANK_CFG_W (BANK_CFG_W),
    .COL_CFG_W  (COL_CFG_W),
    .ROW_LIMIT  (ROW_FIELD_MAX),
    .DEFAULT_ROW(DEFAULT_ROW),
    .RESET_BANK (3),
    .RESET_COL  (10),
    .RESET_WCODE(2)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .apply    (cfg_apply),
    .row_in   (cfg_row_bits),
    .bank_in  (cfg_bank_bits),
    .col_in   (cfg_col_bits),
    .two_cs_in(cfg_two_cs),
    .wcode_in (cfg_if_width),
    .row_q    (eff_row),
    .bank_q   (eff_bank),
    .col_q    (eff_col),
    .two_cs_q (eff_two_cs),
    .lane_q   (eff_lane),
    .order_q  (eff_order)
  );

  dram_size_calc #(
    .ADDR_W    (ADDR_W),
    .SIZE_W    (SIZE_W),
    .ROW_CFG_W (ROW_CFG_W),
    .BANK_CFG_W(BANK_CFG_W),
    .COL_CFG_W (COL_CFG_W)
  ) u_size (
    .addr  (addr),
    .row   (eff_row),
    .bank  (eff_bank),
    .col   (eff_col),
    .two_cs(eff_two_cs),
    .lane  (eff_lane),
    .size  (map_size),
    .oor   (map_oor)
  );

  dram_field_slicer #(
    .ADDR_W    (ADDR_W),
    .ROW_CFG_W (ROW_CFG_W),
    .BANK_CFG_W(BANK_CFG_W),
    .COL_CFG_W (COL_CFG_W),
    .ROW_OUT_W (ROW_FIELD_MAX),
    .BANK_OUT_W(BANK_FIELD_MAX),
    .COL_OUT_W (COL_FIELD_MAX)
  ) u_slice (
    .addr  (addr),
    .row   (eff_row),
    .bank  (eff_bank),
    .col   (eff_col),
    .two_cs(eff_two_cs),
    .lane  (eff_lane),
    .order (eff_order),
    .cs_f  (map_cs),
    .row_f (map_row),
    .bank_f(map_bank),
    .col_f (map_col)
  );

endmodule

// File: rtl/dram_addr_map_chk.sv
module dram_addr_map_chk #(
  parameter int DEFAULT_ROW = 14
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_apply,
  input logic [5:0]  cfg_row_bits,
  input logic [5:0]  eff_row,
  input logic [2:0]  eff_bank,
  input logic [3:0]  eff_col,
  input logic        eff_two_cs,
  input logic [1:0]  eff_lane,
  input logic        map_cs,
  input logic [30:0] map_row,
  input logic [6:0]  map_bank,
  input logic [14:0] map_col,
  input logic        map_oor,
  input logic [63:0] map_size
);

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_apply |=> ($stable(eff_row) && $stable(eff_bank) && $stable(eff_col) &&
                    $stable(eff_two_cs) && $stable(eff_lane)));

  assert_row_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_apply && cfg_row_bits <= 6'd31) |=> (eff_row == $past(cfg_row_bits)));

  assert_row_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_apply && cfg_row_bits > 6'd31) |=> (eff_row == 6'(DEFAULT_ROW)));

  assert_size_pow2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(map_size) == 1);

  assert_single_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_two_cs && !map_oor) |-> (map_cs == 1'b0));

  assert_field_fit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !map_oor |-> (((map_col >> eff_col) == 15'd0) && ((map_bank >> eff_bank) == 7'd0) &&
                  ((map_row >> eff_row) == 31'd0)));

endmodule

bind dram_addr_map dram_addr_map_chk #(.DEFAULT_ROW(DEFAULT_ROW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_apply   (cfg_apply),
  .cfg_row_bits(cfg_row_bits),
  .eff_row     (eff_row),
  .eff_bank    (eff_bank),
  .eff_col     (eff_col),
  .eff_two_cs  (eff_two_cs),
  .eff_lane    (eff_lane),
  .map_cs      (map_cs),
  .map_row     (map_row),
  .map_bank    (map_bank),
  .map_col     (map_col),
  .map_oor     (map_oor),
  .map_size    (map_size)
);

// File: tb/dram_addr_map_tb.sv
`timescale 1ns/1ps
module dram_addr_map_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_apply = 1'b0;
  logic [5:0]  cfg_row_bits = 6'd0;
  logic [2:0]  cfg_bank_bits = 3'd0;
  logic [3:0]  cfg_col_bits = 4'd0;
  logic        cfg_two_cs = 1'b0;
  logic [2:0]  cfg_if_width = 3'd0;
  logic [31:0] addr = 32'd0;
  logic        map_cs;
  logic [30:0] map_row;
  logic [6:0]  map_bank;
  logic [14:0] map_col;
  logic        map_oor;
  logic [63:0] map_size;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_addr_map u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_apply(cfg_apply), .cfg_row_bits(cfg_row_bits),
    .cfg_bank_bits(cfg_bank_bits), .cfg_col_bits(cfg_col_bits), .cfg_two_cs(cfg_two_cs),
    .cfg_if_width(cfg_if_width), .addr(addr), .map_cs(map_cs), .map_row(map_row),
    .map_bank(map_bank), .map_col(map_col), .map_oor(map_oor), .map_size(map_size)
  );

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Data bytes per width code, written from the requirement table.
  function automatic int data_bytes(input int code);
    if (code == 1 || code == 3) return 2;
    if (code == 2 || code == 4) return 4;
    return 1;
  endfunction

  function automatic int lane_of(input int bytes);
    return (bytes == 4) ? 2 : (bytes == 2) ? 1 : 0;
  endfunction

  function automatic longint unsigned exp_size(input int r, input int b, input int c,
                                               input int two, input int code);
    return (64'd1 << (r + b + c)) * (two ? 2 : 1) * data_bytes(code);
  endfunction

  function automatic longint unsigned pack(input int r, input int b, input int c, input int two,
                                           input int code, input longint unsigned row,
                                           input longint unsigned cs, input longint unsigned bank,
                                           input longint unsigned col, input longint unsigned bofs);
    longint unsigned a;
    int lane;
    lane = lane_of(data_bytes(code));
    if (two) begin
      a = row;
      a = (a << 1) | cs;
    end else begin
      a = row;
    end
    a = (a << b) | bank;
    a = (a << c) | col;
    a = (a << lane) | bofs;
    return a;
  endfunction

  task automatic apply_cfg(input int r, input int b, input int c, input int two, input int code);
    @(negedge clk);
    cfg_row_bits  = 6'(r);
    cfg_bank_bits = 3'(b);
    cfg_col_bits  = 4'(c);
    cfg_two_cs    = 1'(two);
    cfg_if_width  = 3'(code);
    cfg_apply     = 1'b1;
    @(negedge clk);
    cfg_apply = 1'b0;
    #1;
  endtask

  task automatic drive_addr(input longint unsigned a);
    addr = 32'(a);
    #1;
  endtask

  task automatic t_reset();
    drive_addr(0);
    chk("R1 reset size", map_size, 64'h2000_0000);
    chk("R1 reset row", map_row, 0);
    chk("R1 reset oor", map_oor, 0);
    drive_addr(32'h2000_0000);
    chk("R1 reset oor at size", map_oor, 1);
  endtask

  task automatic t_one_cs();
    longint unsigned a;
    apply_cfg(13, 3, 10, 0, 2);
    a = pack(13, 3, 10, 0, 2, 64'h1ABC, 0, 5, 64'h2F3, 3);
    drive_addr(a);
    chk("R4 order0 row", map_row, 64'h1ABC);
    chk("R4 order0 bank", map_bank, 5);
    chk("R6 order0 col", map_col, 64'h2F3);
    chk("R4 order0 cs", map_cs, 0);
    chk("R7 order0 size", map_size, exp_size(13, 3, 10, 0, 2));
  endtask

  task automatic t_two_cs();
    longint unsigned a;
    apply_cfg(12, 3, 9, 1, 1);
    a = pack(12, 3, 9, 1, 1, 64'hA5C, 1, 6, 64'h155, 1);
    drive_addr(a);
    chk("R5 order2 row", map_row, 64'hA5C);
    chk("R5 order2 cs", map_cs, 1);
    chk("R5 order2 bank", map_bank, 6);
    chk("R6 order2 col", map_col, 64'h155);
    a = pack(12, 3, 9, 1, 1, 64'hA5C, 0, 6, 64'h155, 0);
    drive_addr(a);
    chk("R5 order2 cs0", map_cs, 0);
    chk("R5 order2 row cs0", map_row, 64'hA5C);
    chk("R7 order2 size", map_size, exp_size(12, 3, 9, 1, 1));
  endtask

  task automatic t_widths();
    for (int code = 0; code < 8; code++) begin
      longint unsigned a;
      apply_cfg(14, 3, 10, 0, code);
      a = pack(14, 3, 10, 0, code, 3, 0, 1, 7, 0);
      drive_addr(a);
      chk($sformatf("R3 col code %0d", code), map_col, 7);
      chk($sformatf("R3 bank code %0d", code), map_bank, 1);
      chk($sformatf("R8 size code %0d", code), map_size, exp_size(14, 3, 10, 0, code));
    end
  endtask

  task automatic t_row_limit();
    apply_cfg(40, 2, 9, 0, 0);
    chk("R9 row 40 fallback size", map_size, exp_size(14, 2, 9, 0, 0));
    apply_cfg(63, 2, 9, 0, 0);
    chk("R9 row 63 fallback size", map_size, exp_size(14, 2, 9, 0, 0));
    apply_cfg(31, 0, 0, 0, 0);
    chk("R9 row 31 size", map_size, 64'h8000_0000);
    drive_addr(32'h7FFF_FFFF);
    chk("R9 row 31 row", map_row, 64'h7FFF_FFFF);
    chk("R10 row 31 in range", map_oor, 0);
    drive_addr(32'h8000_0000);
    chk("R10 row 31 out of range", map_oor, 1);
  endtask

  task automatic t_range();
    longint unsigned sz;
    apply_cfg(10, 2, 8, 1, 2);
    sz = exp_size(10, 2, 8, 1, 2);
    chk("R7 range size", map_size, sz);
    drive_addr(sz - 1);
    chk("R10 size-1 oor", map_oor, 0);
    chk("R6 size-1 row", map_row, 64'h3FF);
    chk("R5 size-1 cs", map_cs, 1);
    chk("R6 size-1 bank", map_bank, 3);
    chk("R6 size-1 col", map_col, 64'hFF);
    drive_addr(sz);
    chk("R10 size oor", map_oor, 1);
    drive_addr(32'hFFFF_FFFF);
    chk("R10 top oor", map_oor, 1);
  endtask

  task automatic t_hold();
    longint unsigned sz;
    sz = exp_size(10, 2, 8, 1, 2);
    drive_addr(sz - 1);
    @(negedge clk);
    cfg_row_bits = 6'd5;
    cfg_two_cs   = 1'b0;
    cfg_if_width = 3'd0;
    cfg_col_bits = 4'd3;
    repeat (4) @(negedge clk);
    #1;
    chk("R2 hold size", map_size, sz);
    chk("R2 hold row", map_row, 64'h3FF);
    chk("R2 hold cs", map_cs, 1);
    apply_cfg(5, 2, 3, 0, 0);
    chk("R2 apply size", map_size, exp_size(5, 2, 3, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_one_cs();
    t_two_cs();
    t_widths();
    t_row_limit();
    t_range();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule